// File: doc/BRIEF.md
# Debug Memory Access Port

This block turns register accesses from a debug port into single-word transactions on a memory-mapped debug bus. The debug side presents one request per cycle. Each request carries a 4-bit bank number, a 2-bit index inside the bank, a read/write flag and 32 bits of write data. The block holds two pieces of state: a transfer address and a control word. Accesses to the data register, or to one of four banked-data registers, drive a bus transaction. The block also answers read-only queries for a debug ROM table base and an identification constant.

A register access that does not touch the bus is answered in the cycle after the request. A bus access is answered one cycle after the bus acknowledges it. While a transaction is in flight, or while its completion is still waiting to be reported, every new request is refused with a wait code and has no effect. The debugger then retries it.

Top module: `dbg_mem_port`

## Requirements
- R1: A register is selected by offset = {bank, index, 2'b00}. A request that does not use the bus and arrives while the block is idle is answered one cycle later with rsp_valid high and code OK. Write answers carry zero data.
- R2: Offset 0x04 is the transfer address. A write loads all 32 bits, and a read returns the held value.
- R3: Offset 0x00 is the control word. Bits [1:0] hold the increment mode and can be written. Bit 4 is the sticky error flag. All other bits read as zero.
- R4: An access to offset 0x0C raises bus_req in the cycle after the request, with bus_addr equal to the transfer address. bus_req stays high with the command held stable until bus_ack. The answer comes one cycle after bus_ack. A read answer returns the bus data, and a write answer returns zero.
- R5: An access to offset 0x10 + 4x (bank 1, index x) targets address {TAR[31:4], x, 2'b00}.
- R6: Banked-data accesses never change the transfer address.
- R7: With increment mode 01, the transfer address grows by 4 after each error-free data-register transfer. Modes 00, 10 and 11 leave it unchanged, and so does any transfer that ends in error.
- R8: Offset 0xF8 reads the BASE_VALUE parameter and offset 0xFC reads the ID_VALUE parameter. Writes to either are ignored.
- R9: Every other offset, including 0x08, 0x20 to 0xF4, and bank 15 indices 0 and 1, reads as zero and ignores writes.
- R10: A request that arrives while bus_req is high, or while a completion is still unreported, gets code WAIT the next cycle and changes no state. If a request arrives in the acknowledge cycle, the completion answer is reported in the first cycle with no request.
- R11: If bus_err is high with bus_ack, the answer carries code FAULT with zero data and the sticky error flag is set. A control-word write with bit 4 set clears the flag. A write with bit 4 clear keeps it.
- R12: Response codes are 2'b00 OK, 2'b01 WAIT and 2'b10 FAULT. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request, one cycle |
| req_bank | input | 4 | Bank number |
| req_idx | input | 2 | Register index inside the bank |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Answer present |
| rsp_code | output | 2 | OK, WAIT or FAULT |
| rsp_rdata | output | 32 | Read data of the answer |
| bus_req | output | 1 | Bus transaction pending |
| bus_addr | output | 32 | Bus byte address |
| bus_wr | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus completes the transaction |
| bus_err | input | 1 | Bus reports an error with bus_ack |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The bench targets a request that lands exactly in the acknowledge cycle. If the design dropped that request, it would lose an answer; if it let the completion overwrite the wait code, the answer would show up with the wrong code. The bench also runs banked-data accesses with increment enabled, where a design that shared the increment path would move the held address. It runs erroring transfers with increment on, where a wrong design would advance the address, and it checks that control-word writes with bit 4 clear leave the sticky flag alone. Bus latencies from zero to several cycles check that the answer follows bus_ack by exactly one cycle and that the command stays still while it waits.

// File: rtl/dmap_pkg.sv
package dmap_pkg;

    localparam int DW         = 32;
    localparam int BANK_W     = 4;
    localparam int IDX_W      = 2;
    localparam int INC_LSB    = 0;
    localparam int INC_W      = 2;
    localparam int ERR_BIT    = 4;
    localparam int STEP_BYTES = DW / 8;
    localparam int LANE_W     = $clog2(STEP_BYTES);

    localparam logic [INC_W-1:0] INC_SINGLE = 2'b01;

    typedef enum logic [1:0] {
        RSP_OK    = 2'b00,
        RSP_WAIT  = 2'b01,
        RSP_FAULT = 2'b10
    } rsp_e;

    typedef enum logic [2:0] {
        K_CTRL,
        K_ADDR,
        K_DATA,
        K_WIN,
        K_BASE,
        K_IDENT,
        K_RSVD
    } kind_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic          wr;
        logic [DW-1:0] wdata;
        logic          via_data;
    } bus_cmd_t;

    typedef struct packed {
        logic          valid;
        rsp_e          code;
        logic [DW-1:0] data;
    } rsp_t;

    function automatic kind_e decode_kind(input logic [BANK_W-1:0] bank,
                                          input logic [IDX_W-1:0]  idx);
        kind_e k;
        k = K_RSVD;
        if (bank == 4'h0) begin
            case (idx)
                2'd0:    k = K_CTRL;
                2'd1:    k = K_ADDR;
                2'd3:    k = K_DATA;
                default: k = K_RSVD;
            endcase
        end else if (bank == 4'h1) begin
            k = K_WIN;
        end else if (bank == 4'hF) begin
            case (idx)
                2'd2:    k = K_BASE;
                2'd3:    k = K_IDENT;
                default: k = K_RSVD;
            endcase
        end
        return k;
    endfunction

    function automatic logic [DW-1:0] window_addr(input logic [DW-1:0]    base,
                                                  input logic [IDX_W-1:0] idx);
        logic [DW-1:0] a;
        a = base;
        a[IDX_W+LANE_W-1:0] = {idx, {LANE_W{1'b0}}};
        return a;
    endfunction

    function automatic logic [DW-1:0] ctrl_word(input logic [INC_W-1:0] inc,
                                                input logic             err);
        logic [DW-1:0] v;
        v = '0;
        v[INC_LSB +: INC_W] = inc;
        v[ERR_BIT]          = err;
        return v;
    endfunction

endpackage

// File: rtl/dmap_regs.sv
module dmap_regs
    import dmap_pkg::*;
#(
    parameter logic [DW-1:0] BASE_VALUE = '0,
    parameter logic [DW-1:0] ID_VALUE   = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  kind_e         kind,
    input  logic [DW-1:0] wdata,
    input  logic          cmp_fire,
    input  logic          cmp_via_data,
    input  logic          cmp_err,
    output logic [DW-1:0] tar,
    output logic          err,
    output logic [DW-1:0] rd_data
);

    logic [INC_W-1:0] inc_q;
    logic             ctrl_wr;
    logic             bump;

    assign ctrl_wr = wr_en && (kind == K_CTRL);
    assign bump    = cmp_fire && cmp_via_data && !cmp_err && (inc_q == INC_SINGLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tar   <= '0;
            inc_q <= '0;
            err   <= 1'b0;
        end else begin
            if (wr_en && kind == K_ADDR) begin
                tar <= wdata;
            end else if (bump) begin
                tar <= tar + DW'(STEP_BYTES);
            end
            if (ctrl_wr) begin
                inc_q <= wdata[INC_LSB +: INC_W];
            end
            if (cmp_fire && cmp_err) begin
                err <= 1'b1;
            end else if (ctrl_wr && wdata[ERR_BIT]) begin
                err <= 1'b0;
            end
        end
    end

    always_comb begin
        case (kind)
            K_CTRL:  rd_data = ctrl_word(inc_q, err);
            K_ADDR:  rd_data = tar;
            K_BASE:  rd_data = BASE_VALUE;
            K_IDENT: rd_data = ID_VALUE;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dmap_bus.sv
module dmap_bus
    import dmap_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  bus_cmd_t      cmd,
    input  logic          hold,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic [DW-1:0] bus_addr,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          cmp_fire,
    output logic          cmp_via_data,
    output logic          cmp_err,
    output logic          busy,
    output rsp_t          done
);

    bus_cmd_t cur_q;
    logic     req_q;
    logic     pend_q;
    rsp_t     pend_rsp_q;
    rsp_t     live;

    assign cmp_fire     = req_q && bus_ack;
    assign cmp_err      = bus_err;
    assign cmp_via_data = cur_q.via_data;
    assign busy         = req_q || pend_q;

    assign bus_req   = req_q;
    assign bus_addr  = cur_q.addr;
    assign bus_wr    = cur_q.wr;
    assign bus_wdata = cur_q.wdata;

    always_comb begin
        live.valid = 1'b1;
        live.code  = bus_err ? RSP_FAULT : RSP_OK;
        live.data  = (cur_q.wr || bus_err) ? '0 : bus_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= 1'b0;
            cur_q      <= '0;
            pend_q     <= 1'b0;
            pend_rsp_q <= '0;
        end else begin
            if (start) begin
                req_q <= 1'b1;
                cur_q <= cmd;
            end else if (cmp_fire) begin
                req_q <= 1'b0;
            end
            if (cmp_fire && hold) begin
                pend_q     <= 1'b1;
                pend_rsp_q <= live;
            end else if (!hold) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        done = '0;
        if (!hold) begin
            if (pend_q) begin
                done = pend_rsp_q;
            end else if (cmp_fire) begin
                done = live;
            end
        end
    end

endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port
    import dmap_pkg::*;
#(
    parameter logic [DW-1:0] BASE_VALUE = 32'h4000_1003,
    parameter logic [DW-1:0] ID_VALUE   = 32'h2477_0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              req_wr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DW-1:0]     rsp_rdata,
    output logic              bus_req,
    output logic [DW-1:0]     bus_addr,
    output logic              bus_wr,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DW-1:0]     bus_rdata
);

    kind_e         kind;
    logic          uses_bus;
    logic          busy_w;
    logic          accept;
    logic [DW-1:0] tar_w;
    logic          err_w;
    logic [DW-1:0] rd_data;
    logic          cmp_fire;
    logic          cmp_via_data;
    logic          cmp_err;
    bus_cmd_t      cmd;
    rsp_t          done;
    rsp_t          rsp_q;

    assign kind     = decode_kind(req_bank, req_idx);
    assign uses_bus = (kind == K_DATA) || (kind == K_WIN);
    assign accept   = req_valid && !busy_w;

    always_comb begin
        cmd.addr     = (kind == K_DATA) ? tar_w : window_addr(tar_w, req_idx);
        cmd.wr       = req_wr;
        cmd.wdata    = req_wdata;
        cmd.via_data = (kind == K_DATA);
    end

    dmap_regs #(
        .BASE_VALUE(BASE_VALUE),
        .ID_VALUE  (ID_VALUE)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (accept && req_wr && !uses_bus),
        .kind        (kind),
        .wdata       (req_wdata),
        .cmp_fire    (cmp_fire),
        .cmp_via_data(cmp_via_data),
        .cmp_err     (cmp_err),
        .tar         (tar_w),
        .err         (err_w),
        .rd_data     (rd_data)
    );

    dmap_bus u_bus (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && uses_bus),
        .cmd         (cmd),
        .hold        (req_valid),
        .bus_ack     (bus_ack),
        .bus_err     (bus_err),
        .bus_rdata   (bus_rdata),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .cmp_fire    (cmp_fire),
        .cmp_via_data(cmp_via_data),
        .cmp_err     (cmp_err),
        .busy        (busy_w),
        .done        (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= '0;
            if (req_valid) begin
                if (busy_w) begin
                    rsp_q.valid <= 1'b1;
                    rsp_q.code  <= RSP_WAIT;
                end else if (!uses_bus) begin
                    rsp_q.valid <= 1'b1;
                    rsp_q.code  <= RSP_OK;
                    rsp_q.data  <= req_wr ? '0 : rd_data;
                end
            end else if (done.valid) begin
                rsp_q <= done;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_code  = rsp_q.code;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/dmap_checker.sv
module dmap_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [3:0]    req_bank,
    input logic [1:0]    req_idx,
    input logic          rsp_valid,
    input logic [1:0]    rsp_code,
    input logic          bus_req,
    input logic [DW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack,
    input logic          bus_err,
    input logic [DW-1:0] tar_q,
    input logic          err_q,
    input logic          busy_q
);

    a_r1_idle_reg_ok: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy_q && req_bank != 4'h1 && !(req_bank == 4'h0 && req_idx == 2'd3))
        |=> (rsp_valid && rsp_code == 2'b00));

    a_r4_data_addr: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_req) && $past(req_bank) == 4'h0) |-> (bus_addr == tar_q));

    a_r4_hold_cmd: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));

    a_r5_window_addr: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_req) && $past(req_bank) == 4'h1)
        |-> (bus_addr[DW-1:4] == tar_q[DW-1:4] && bus_addr[3:2] == $past(req_idx) && bus_addr[1:0] == 2'b00));

    a_r6_window_keeps_tar: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bank == 4'h1 && !bus_req) |=> $stable(tar_q));

    a_r10_wait_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && bus_req) |=> (rsp_valid && rsp_code == 2'b01));

    a_r11_sticky_set: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_err) |=> err_q);

    a_r12_legal_code: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_code != 2'b11));

endmodule

bind dbg_mem_port dmap_checker #(.DW(32)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_bank (req_bank),
    .req_idx  (req_idx),
    .rsp_valid(rsp_valid),
    .rsp_code (rsp_code),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .tar_q    (tar_w),
    .err_q    (err_w),
    .busy_q   (busy_w)
);

// File: tb/tb_dbg_mem_port.sv
`timescale 1ns/1ps
module tb_dbg_mem_port;

    localparam logic [31:0] BASE = 32'h4000_1003;
    localparam logic [31:0] IDV  = 32'h2477_0011;
    localparam logic [31:0] RMIX = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_bank = '0;
    logic [1:0]  req_idx = '0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_rdata;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    dbg_mem_port #(.BASE_VALUE(BASE), .ID_VALUE(IDV)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_bank(req_bank), .req_idx(req_idx),
        .req_wr(req_wr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    // behavioural reference state
    logic [31:0] m_tar, m_addr, m_wdata, m_pdata, e_rd;
    logic [1:0]  m_inc, m_pcode, e_code;
    logic        m_err, m_busreq, m_wr, m_isdata, m_pend, e_rv;
    int          n_vec = 0;
    int          n_bad = 0;
    int          lat = 0;
    int          cnt = 0;
    string       tag = "R12";

    always @(posedge clk) begin
        logic       ack, busy, cerr;
        logic [7:0] off;
        logic [31:0] cdata;
        if (rst) begin
            m_tar = 0; m_addr = 0; m_wdata = 0; m_pdata = 0; e_rd = 0;
            m_inc = 0; m_pcode = 0; e_code = 0;
            m_err = 0; m_busreq = 0; m_wr = 0; m_isdata = 0; m_pend = 0; e_rv = 0;
        end else begin
            ack  = bus_ack && m_busreq;
            busy = m_busreq || m_pend;
            e_rv = 0; e_code = 0; e_rd = 0;
            if (m_pend && !req_valid) begin
                e_rv = 1; e_code = m_pcode; e_rd = m_pdata; m_pend = 0;
            end
            if (req_valid) begin
                e_rv = 1;
                if (busy) begin
                    e_code = 2'b01;
                end else begin
                    off = {req_bank, req_idx, 2'b00};
                    case (off)
                        8'h00: if (req_wr) begin
                                   m_inc = req_wdata[1:0];
                                   if (req_wdata[4]) m_err = 0;
                               end else e_rd = {27'b0, m_err, 2'b00, m_inc};
                        8'h04: if (req_wr) m_tar = req_wdata; else e_rd = m_tar;
                        8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C: begin
                            m_busreq = 1;
                            m_addr   = (off == 8'h0C) ? m_tar : {m_tar[31:4], off[3:0]};
                            m_wr     = req_wr;
                            m_wdata  = req_wdata;
                            m_isdata = (off == 8'h0C);
                            e_rv     = 0;
                        end
                        8'hF8: if (!req_wr) e_rd = BASE;
                        8'hFC: if (!req_wr) e_rd = IDV;
                        default: ;
                    endcase
                end
            end
            if (ack) begin
                cerr  = bus_err;
                cdata = (m_wr || cerr) ? 32'h0 : bus_rdata;
                m_busreq = 0;
                if (cerr) m_err = 1;
                if (m_isdata && !cerr && m_inc == 2'b01) m_tar = m_tar + 4;
                if (req_valid) begin
                    m_pend = 1; m_pcode = cerr ? 2'b10 : 2'b00; m_pdata = cdata;
                end else begin
                    e_rv = 1; e_code = cerr ? 2'b10 : 2'b00; e_rd = cdata;
                end
            end
        end
    end

    // bus responder: acknowledges after lat waiting cycles; addresses 0xE....... error
    always @(negedge clk) begin
        if (!rst && m_busreq) begin
            if (cnt >= lat) begin
                bus_ack   = 1;
                bus_rdata = m_addr ^ RMIX;
                bus_err   = (m_addr[31:28] == 4'hE);
            end else begin
                cnt++;
                bus_ack = 0;
            end
        end else begin
            cnt = 0; bus_ack = 0; bus_err = 0;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            n_vec++;
            if (rsp_valid !== e_rv || (e_rv && (rsp_code !== e_code || rsp_rdata !== e_rd))) begin
                n_bad++;
                $display("FAIL %s rsp: got v=%0b c=%0d d=%h exp v=%0b c=%0d d=%h",
                         tag, rsp_valid, rsp_code, rsp_rdata, e_rv, e_code, e_rd);
            end
            if (bus_req !== m_busreq ||
                (m_busreq && (bus_addr !== m_addr || bus_wr !== m_wr || bus_wdata !== m_wdata))) begin
                n_bad++;
                $display("FAIL %s bus: got r=%0b a=%h w=%0b d=%h exp r=%0b a=%h w=%0b d=%h",
                         tag, bus_req, bus_addr, bus_wr, bus_wdata, m_busreq, m_addr, m_wr, m_wdata);
            end
        end
    end

    task automatic drive(input logic [3:0] b, input logic [1:0] i, input logic w, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_bank = b; req_idx = i; req_wr = w; req_wdata = d;
    endtask

    task automatic release_req();
        @(negedge clk);
        req_valid = 0; req_wr = 0; req_wdata = 0;
    endtask

    task automatic acc(input logic [3:0] b, input logic [1:0] i, input logic w, input logic [31:0] d);
        drive(b, i, w, d);
        release_req();
        while (m_busreq || m_pend) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input logic [3:0] b, input logic [1:0] i, input logic w, input int n);
        for (int k = 0; k < n; k++) drive(b, i, w, 32'h0000_0F00 + k);
        release_req();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R12"; repeat (2) @(negedge clk);            // reset state, idle codes

        tag = "R3";                                        // control word layout
        acc(4'h0, 2'd0, 0, 0);
        acc(4'h0, 2'd0, 1, 32'hFFFF_FFFF);
        acc(4'h0, 2'd0, 0, 0);
        acc(4'h0, 2'd0, 1, 32'h0000_0000);

        tag = "R2";                                        // transfer address
        acc(4'h0, 2'd1, 1, 32'h1000_0040);
        acc(4'h0, 2'd1, 0, 0);

        tag = "R4";                                        // data register, latencies 0 and 3
        for (int l = 0; l < 4; l += 3) begin
            lat = l;
            acc(4'h0, 2'd3, 0, 0);
            acc(4'h0, 2'd3, 1, 32'hCAFE_0000 + l);
        end

        tag = "R7";                                        // increment modes
        lat = 1;
        acc(4'h0, 2'd0, 1, 32'h1);
        for (int k = 0; k < 3; k++) acc(4'h0, 2'd3, k[0], 32'h11 * k);
        acc(4'h0, 2'd1, 0, 0);
        acc(4'h0, 2'd0, 1, 32'h2);
        acc(4'h0, 2'd3, 0, 0);
        acc(4'h0, 2'd0, 1, 32'h3);
        acc(4'h0, 2'd3, 0, 0);
        acc(4'h0, 2'd1, 0, 0);

        tag = "R5";                                        // banked window
        acc(4'h0, 2'd0, 1, 32'h1);
        acc(4'h0, 2'd1, 1, 32'h2000_0034);
        for (int x = 0; x < 4; x++) begin
            acc(4'h1, 2'(x), 0, 0);
            acc(4'h1, 2'(x), 1, 32'hB0 + x);
        end
        tag = "R6";
        acc(4'h0, 2'd1, 0, 0);

        tag = "R8";                                        // read-only constants
        acc(4'hF, 2'd2, 0, 0);
        acc(4'hF, 2'd3, 0, 0);
        acc(4'hF, 2'd2, 1, 32'hDEAD_BEEF);
        acc(4'hF, 2'd3, 1, 32'hDEAD_BEEF);
        acc(4'hF, 2'd2, 0, 0);
        acc(4'hF, 2'd3, 0, 0);

        tag = "R9";                                        // reserved offsets
        acc(4'h0, 2'd2, 1, 32'hFFFF_FFFF);
        acc(4'h0, 2'd2, 0, 0);
        for (int b = 2; b < 15; b += 5) begin
            acc(4'(b), 2'd1, 1, 32'h7777_7777);
            acc(4'(b), 2'd1, 0, 0);
        end
        acc(4'hF, 2'd0, 0, 0);
        acc(4'hF, 2'd1, 1, 32'h1);
        acc(4'h0, 2'd1, 0, 0);
        acc(4'h0, 2'd0, 0, 0);

        tag = "R10";                                       // busy, wait and collision
        lat = 4;
        drive(4'h0, 2'd3, 0, 0);
        drive(4'h0, 2'd1, 1, 32'h9999_0000);
        drive(4'h0, 2'd0, 1, 32'h0);
        release_req();
        while (m_busreq || m_pend) @(negedge clk);
        acc(4'h0, 2'd1, 0, 0);
        acc(4'h0, 2'd0, 0, 0);
        for (int l = 0; l < 3; l++) begin
            lat = l;
            drive(4'h0, 2'd3, 0, 0);
            burst(4'h0, 2'd0, 0, 5);
            while (m_busreq || m_pend) @(negedge clk);
            @(negedge clk);
        end

        tag = "R11";                                       // bus error and sticky flag
        lat = 2;
        acc(4'h0, 2'd0, 1, 32'h1);
        acc(4'h0, 2'd1, 1, 32'hE000_0100);
        acc(4'h0, 2'd3, 0, 0);
        acc(4'h0, 2'd1, 0, 0);
        acc(4'h0, 2'd0, 0, 0);
        acc(4'h1, 2'd2, 1, 32'h5);
        acc(4'h0, 2'd0, 1, 32'h1);
        acc(4'h0, 2'd0, 0, 0);
        acc(4'h0, 2'd0, 1, 32'h11);
        acc(4'h0, 2'd0, 0, 0);

        tag = "R1";
        acc(4'h0, 2'd1, 1, 32'h0000_0A00);
        acc(4'h0, 2'd1, 0, 0);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule